// File: doc/BRIEF.md
# Raster Line and Dot Interrupt Timer

This block gives a video controller two interrupt sources locked to the raster. A line counter counts horizontal-blank-start pulses and is cleared at the end of vertical blank. It raises a one-cycle pulse when its value reaches a programmable line number.

A second counter is a dot down-counter. It is armed from a reload register at horizontal-blank start and counts down on a dot-rate clock enable. It pulses when it runs out. A mode bit chooses whether that pulse may occur on every scanline or only on the scanline selected by the line compare. This gives software a hook at a chosen horizontal position on a chosen line.

Software programs three write-only registers through a simple word write port. The sync inputs are single-cycle pulses that are already synchronous to the system clock. A master enable freezes both counters and suppresses both pulses while it is clear.

Top module: `raster_irq_timer`

## Requirements
- R1: Register writes are decoded by byte offset:
  - 0x90 loads the line compare from data bits 9:0.
  - 0x94 loads the dot reload from data bits 8:0.
  - 0x98 loads the mode register: bit 8 is the line gate and bit 0 is the enable.
  - Writes to any other offset have no effect.
  - The mode register resets to zero, so no pulse appears out of reset.
- R2: While enabled, the line counter clears on `vblank_end` and otherwise increments on `hblank_start`. Clearing wins when both pulses arrive together. The count wraps from 1023 to 0.
- R3: `line_irq` is high for exactly one clock, in the cycle after a `hblank_start` that brings the line counter to a nonzero compare value.
- R4: With a compare value of 0, `line_irq` pulses in the cycle after `vblank_end` and never as a result of counting.
- R5: A `hblank_start` loads the dot counter from the reload register only while the dot counter is stopped. The dot counter is stopped after reset and after it reaches zero. A `hblank_start` that arrives while the dot counter is running has no effect on it.
- R6: A running dot counter decrements once per `dot_ce` cycle. The `dot_ce` in the load cycle does not count. After the decrement that reaches zero, the counter stops and `dot_irq` is high for one clock in the next cycle. A reload value N therefore pulses on the N-th counted `dot_ce`.
- R7: A reload value of 0 gives a span of 512 counted `dot_ce` cycles.
- R8: With mode bit 8 clear, every expiry of the dot counter pulses `dot_irq`. With bit 8 set, an expiry pulses only if the line counter equals the compare value in that cycle. The value checked is the line counter before any update from a simultaneous `hblank_start`.
- R9: While the enable bit is clear, both counters hold their values and neither output pulses. Register writes still take effect. Counting resumes from the held values when the enable is set again.
- R10: A compare value above the number of lines in the frame never produces `line_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the register written |
| wr_data | input | 32 | Write data word |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blank |
| vblank_end | input | 1 | One-cycle pulse at the end of vertical blank |
| dot_ce | input | 1 | Dot-rate clock enable |
| line_irq | output | 1 | One-cycle line compare interrupt pulse |
| dot_irq | output | 1 | One-cycle dot timer interrupt pulse |

## Verification
The dot counter can expire in the same cycle as a `hblank_start` that moves the line counter onto or off the compare line. The gate must then use the line value from before that edge.

The bench provokes this in two ways. In the first, the counter runs out on the pulse that advances the line from 1 to a compare of 2. Here `line_irq` must fire and `dot_irq` must stay low. In the second, the counter runs out on the pulse that leaves line 2, and there `dot_irq` must fire.

The same cycle must also not reload the dot counter, since it was still running. A behavioural reference model decides both outputs on every clock, and pulse counts per scenario confirm the result.

// File: rtl/raster_tmr_pkg.sv
package raster_tmr_pkg;

  // Register offsets (byte addresses within the block window)
  localparam int OFS_LCMP = 'h90;
  localparam int OFS_DREL = 'h94;
  localparam int OFS_MODE = 'h98;

  // Field positions inside the mode word
  localparam int MODE_GATE_BIT = 8;
  localparam int MODE_EN_BIT   = 0;

  typedef struct packed {
    logic gate;   // dot pulse only on the compared line
    logic en;     // master run enable
  } tmr_mode_t;

endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import raster_tmr_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] cmp_q,
  output logic [DOT_W-1:0]  rel_q,
  output tmr_mode_t         mode_q
);
  logic      cmp_we, rel_we, mode_we;
  tmr_mode_t mode_d;
  logic      unused_data;

  assign unused_data = ^wr_data;

  always_comb begin
    cmp_we      = wr_en && (wr_addr == ADDR_W'(OFS_LCMP));
    rel_we      = wr_en && (wr_addr == ADDR_W'(OFS_DREL));
    mode_we     = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
    mode_d.gate = wr_data[MODE_GATE_BIT];
    mode_d.en   = wr_data[MODE_EN_BIT];
  end

  // Compare and reload words carry no reset value by design.
  always_ff @(posedge clk) begin
    if (cmp_we) cmp_q <= wr_data[LINE_W-1:0];
    if (rel_we) rel_q <= wr_data[DOT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  // R1: a write elsewhere never disturbs the mode register
  assert_stray_write_keeps_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == ADDR_W'(OFS_MODE))) |=> $stable(mode_q));
endmodule

// File: rtl/rt_line_ctr.sv
module rt_line_ctr #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hbl,
  input  logic              vbl,
  input  logic [LINE_W-1:0] cmp,
  output logic [LINE_W-1:0] lcnt,
  output logic              line_eq,
  output logic              line_irq
);
  logic [LINE_W-1:0] lcnt_inc, lcnt_d;
  logic              cnt_ce, irq_d;

  always_comb begin
    lcnt_inc = lcnt + 1'b1;
    cnt_ce   = en && (hbl || vbl);
    lcnt_d   = vbl ? '0 : lcnt_inc;
    irq_d    = 1'b0;
    if (en) begin
      if (vbl)      irq_d = (cmp == '0);
      else if (hbl) irq_d = (cmp != '0) && (lcnt_inc == cmp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lcnt <= '0;
    else if (cnt_ce) lcnt <= lcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_irq <= 1'b0;
    else        line_irq <= irq_d;
  end

  assign line_eq = (lcnt == cmp);

  // R2: end of vertical blank clears the count
  assert_vbl_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vbl) |=> (lcnt == '0));
  // R9: counter frozen while disabled
  assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(lcnt) && !line_irq);
  // R3: a pulse always lands on the compared line
  assert_line_irq_on_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> (lcnt == $past(cmp)));
endmodule

// File: rtl/rt_dot_ctr.sv
module rt_dot_ctr #(
  parameter int DOT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hbl,
  input  logic             dce,
  input  logic [DOT_W-1:0] reload,
  input  logic             gate,
  input  logic             line_eq,
  output logic             dot_irq
);
  localparam int CNT_W = DOT_W + 1;
  localparam logic [CNT_W-1:0] FULL_SPAN = CNT_W'(1) << DOT_W;

  logic [CNT_W-1:0] dcnt, dcnt_d;
  logic             run_q, run_d, cnt_ce, irq_d;

  always_comb begin
    dcnt_d = dcnt;
    run_d  = run_q;
    cnt_ce = 1'b0;
    irq_d  = 1'b0;
    if (en) begin
      if (!run_q) begin
        if (hbl) begin
          dcnt_d = (reload == '0) ? FULL_SPAN : {1'b0, reload};
          run_d  = 1'b1;
          cnt_ce = 1'b1;
        end
      end else if (dce) begin
        cnt_ce = 1'b1;
        dcnt_d = dcnt - 1'b1;
        if (dcnt == CNT_W'(1)) begin
          run_d = 1'b0;
          irq_d = !gate || line_eq;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      run_q <= 1'b0;
    end else if (cnt_ce) begin
      dcnt  <= dcnt_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot_irq <= 1'b0;
    else        dot_irq <= irq_d;
  end

  // R6: a pulse means the counter has stopped
  assert_dot_stopped_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |-> !run_q);
  // R5: horizontal blank without a dot enable leaves a running count alone
  assert_no_reload_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && hbl && !dce) |=> $stable(dcnt));
  // R7: the count never exceeds the full span
  assert_span_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= FULL_SPAN);
  // R8: gated pulses only on the compared line
  assert_gated_on_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_irq && $past(gate)) |-> $past(line_eq));
  // R9: no pulse while disabled
  assert_dot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !dot_irq);
endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer
  import raster_tmr_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hblank_start,
  input  logic              vblank_end,
  input  logic              dot_ce,
  output logic              line_irq,
  output logic              dot_irq
);
  logic              rst_ns;
  logic [LINE_W-1:0] cmp_q, lcnt;
  logic [DOT_W-1:0]  rel_q;
  tmr_mode_t         mode_q;
  logic              line_eq;

  rt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  rt_regs #(.LINE_W(LINE_W), .DOT_W(DOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_q(cmp_q), .rel_q(rel_q), .mode_q(mode_q)
  );

  rt_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_ns), .en(mode_q.en), .hbl(hblank_start), .vbl(vblank_end),
    .cmp(cmp_q), .lcnt(lcnt), .line_eq(line_eq), .line_irq(line_irq)
  );

  rt_dot_ctr #(.DOT_W(DOT_W)) u_dot (
    .clk(clk), .rst_n(rst_ns), .en(mode_q.en), .hbl(hblank_start), .dce(dot_ce),
    .reload(rel_q), .gate(mode_q.gate), .line_eq(line_eq), .dot_irq(dot_irq)
  );

  // R4: a zero compare fires only from the end of vertical blank
  assert_zero_cmp_from_vbl_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (line_irq && $past(cmp_q) == '0) |-> $past(vblank_end));
endmodule

// File: tb/sim_raster_irq_timer.sv
`timescale 1ns/1ps
module sim_raster_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hbl = 1'b0, vbl = 1'b0, dce = 1'b0;
  logic        line_irq, dot_irq;

  int n_chk = 0, n_fail = 0;
  int cnt_l = 0, cnt_d = 0, snap_l = 0, snap_d = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  raster_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hblank_start(hbl), .vblank_end(vbl), .dot_ce(dce),
    .line_irq(line_irq), .dot_irq(dot_irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // Behavioural reference model
  int m_cmp = 0, m_rel = 0, m_gate = 0, m_en = 0, m_line = 0, m_dot = 0, m_run = 0;
  int m_lirq = 0, m_dirq = 0;
  int nl, nd, nr, li, di;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate = 0; m_en = 0; m_line = 0; m_dot = 0; m_run = 0; m_lirq = 0; m_dirq = 0;
    end else begin
      nl = m_line; nd = m_dot; nr = m_run; li = 0; di = 0;
      if (m_en != 0) begin
        if (vbl) begin
          nl = 0;
          if (m_cmp == 0) li = 1;
        end else if (hbl) begin
          nl = (m_line + 1) % 1024;
          if (m_cmp != 0 && nl == m_cmp) li = 1;
        end
        if (m_run == 0) begin
          if (hbl) begin nd = (m_rel == 0) ? 512 : m_rel; nr = 1; end
        end else if (dce) begin
          nd = m_dot - 1;
          if (nd == 0) begin
            nr = 0;
            if (m_gate == 0 || m_line == m_cmp) di = 1;
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          8'h90: m_cmp = int'(wr_data[9:0]);
          8'h94: m_rel = int'(wr_data[8:0]);
          8'h98: begin m_gate = int'(wr_data[8]); m_en = int'(wr_data[0]); end
          default: ;
        endcase
      end
      m_line = nl; m_dot = nd; m_run = nr; m_lirq = li; m_dirq = di;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_irq) cnt_l++;
      if (dot_irq)  cnt_d++;
      chk({cur_req, " per-cycle line_irq"}, int'(line_irq), m_lirq);
      chk({cur_req, " per-cycle dot_irq"}, int'(dot_irq), m_dirq);
    end
  end

  task automatic step(input bit h, input bit v, input bit d);
    hbl = h; vbl = v; dce = d;
    @(negedge clk);
    hbl = 1'b0; vbl = 1'b0; dce = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic dots(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic mark();
    #1; snap_l = cnt_l; snap_d = cnt_d;
  endtask

  task automatic verify(input string req, input int exp_l, input int exp_d);
    idle(2);
    #1;
    if (exp_l >= 0) chk({req, " line pulse count"}, cnt_l - snap_l, exp_l);
    if (exp_d >= 0) chk({req, " dot pulse count"}, cnt_d - snap_d, exp_d);
  endtask

  task automatic lines(input int n, input int len);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0);
      dots(len);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, outputs quiet
    repeat (4) @(negedge clk);
    chk("R1 reset line_irq", int'(line_irq), 0);
    chk("R1 reset dot_irq", int'(dot_irq), 0);
    rst_n = 1'b1;
    idle(4);

    // R1/R9: stray offset ignored, disabled block stays quiet
    cur_req = "R9";
    wr(8'h90, 32'h0000_0001);
    wr(8'h94, 32'h0000_0002);
    wr(8'h9C, 32'h0000_0101);
    mark();
    step(0, 1, 0); lines(2, 4);
    verify("R1 stray write ignored", 0, 0);
    wr(8'h98, 32'h0000_0001);
    mark();
    step(1, 0, 0); dots(2);
    verify("R9 held line count resumes", 1, 1);

    // R1/R2/R3/R6: masked compare write, frame of six lines
    cur_req = "R3";
    wr(8'h90, 32'hFFFF_FC03);
    wr(8'h94, 32'h0000_0005);
    mark();
    step(0, 1, 0); lines(6, 8);
    verify("R3 single compare pulse", 1, -1);
    chk("R6 dot pulse per line", cnt_d - snap_d, 6);

    // R2: simultaneous pulses, clear wins
    cur_req = "R2";
    wr(8'h90, 32'h0000_0001);
    mark();
    step(1, 1, 0);
    verify("R2 clear beats increment", 0, -1);
    step(1, 0, 0);
    verify("R2 next line hits compare", 1, -1);
    dots(600);

    // R2: wrap from 1023 to 0
    wr(8'h90, 32'h0000_0005);
    step(0, 1, 0);
    mark();
    for (int i = 0; i < 1029; i++) begin step(1, 0, 0); step(0, 0, 0); end
    verify("R2 wrap gives second hit", 2, -1);
    dots(600);

    // R8: gated dot pulse only on compared line
    cur_req = "R8";
    wr(8'h90, 32'h0000_0003);
    wr(8'h94, 32'h0000_0005);
    wr(8'h98, 32'h0000_0101);
    mark();
    step(0, 1, 0); lines(6, 8);
    verify("R8 gated to one line", 1, 1);

    // R8: expiry coinciding with a line advance uses the old line
    wr(8'h90, 32'h0000_0002);
    wr(8'h94, 32'h0000_0004);
    mark();
    step(0, 1, 0); step(1, 0, 0); dots(3); step(1, 0, 1);
    verify("R8 collision entering compare line", 1, 0);
    mark();
    step(0, 1, 0); step(1, 0, 0); dots(4); step(1, 0, 0); dots(3); step(1, 0, 1);
    verify("R8 collision leaving compare line", 1, 1);
    dots(600);

    // R4: zero compare fires from end of vertical blank only
    cur_req = "R4";
    wr(8'h98, 32'h0000_0001);
    wr(8'h90, 32'h0000_0000);
    mark();
    step(0, 1, 0); lines(5, 2);
    verify("R4 zero compare", 1, -1);
    dots(600);

    // R10: compare beyond frame
    cur_req = "R10";
    wr(8'h90, 32'd1000);
    mark();
    step(0, 1, 0);
    for (int i = 0; i < 20; i++) begin step(1, 0, 0); step(0, 0, 0); end
    step(0, 1, 0);
    verify("R10 out-of-frame compare", 0, -1);
    dots(600);

    // R7: zero reload spans 512
    cur_req = "R7";
    wr(8'h94, 32'h0000_0000);
    mark();
    step(1, 0, 0); dots(511);
    verify("R7 quiet before 512", -1, 0);
    dots(1);
    verify("R7 pulse at 512", -1, 1);

    // R5: horizontal blank while running does not reload
    cur_req = "R5";
    wr(8'h94, 32'h0000_000A);
    mark();
    step(1, 0, 0); dots(3); step(1, 0, 0); dots(6);
    verify("R5 running count kept", -1, 0);
    dots(1);
    verify("R5 pulse at original span", -1, 1);

    // R9: disable mid-count holds the count
    cur_req = "R9";
    wr(8'h94, 32'h0000_0004);
    mark();
    step(1, 0, 0); dots(2);
    wr(8'h98, 32'h0000_0000);
    dots(10); step(1, 0, 0); step(0, 1, 0);
    verify("R9 quiet while disabled", 0, 0);
    wr(8'h98, 32'h0000_0001);
    dots(1);
    verify("R9 resumes from held count", -1, 0);
    dots(1);
    verify("R9 expires after resume", -1, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule